// File: doc/BRIEF.md
# Write-Protect Gate and Status Register

This block guards the write path of a serial memory. It holds the protection state and decides, combinationally, whether each write request is allowed. The protection state is a protect-enable bit and a two-bit protection level. A request names its target: the status register or an array address. The block weighs the target against four things: the write enable latch, the busy flag, the active-low write-protect pin and the stored protection level.

The block also assembles the status byte that a status-read command shifts out. When the command decoder reports a completed write-status command, the block loads new protection bits. It does so only if a status write is allowed at that moment. Because the pin locks the status register only while the protect-enable bit is set, the enable bit stays set for as long as the pin is held low.

Top module: `wp_status_guard`

## Requirements
- R1: After reset the protect-enable bit and both level bits are 0. With the write enable latch and busy low, the status byte is 8'h00.
- R2: When busy is low, the status byte is {protect-enable, 3'b000, level[1], level[0], write-enable latch, 1'b0}. Bit 7 is protect-enable and bit 0 is the busy flag.
- R3: While busy is high, the status byte reads 8'hFF and `allow` is 0.
- R4: While the write enable latch input is 0, `allow` is 0 for every target.
- R5: Array protection compares the top two address bits `hi` against the level. Level 2'b00 protects nothing. Level 2'b01 protects hi==3. Level 2'b10 protects hi>=2. Level 2'b11 protects every address. A protected address is never allowed.
- R6: Hardware protection is active only when `wpPinN` is 0 and protect-enable is 1. While it is active, status-register requests are denied. Otherwise they are allowed whenever the latch is set and busy is low.
- R7: Under hardware protection, writes to unprotected array addresses are still allowed while the latch is set and busy is low.
- R8: An accepted write-status commit loads data bit 7 into protect-enable and data bits 3:2 into the level. The new values show on the status byte from the next clock. Data bits 6:4 and 1:0 are discarded.
- R9: A write-status commit is discarded in three cases: the latch is 0, busy is 1, or hardware protection is active. While `wpPinN` stays low, a set protect-enable bit therefore cannot be cleared.
- R10: With `reqValid` low, `allow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wpPinN | input | 1 | Write-protect pin, active low |
| welSet | input | 1 | Write enable latch state |
| busy | input | 1 | Internal write cycle in progress |
| reqValid | input | 1 | A write request is presented |
| reqIsStatus | input | 1 | 1: target is the status register; 0: target is the array |
| reqAddr | input | ADDR_W | Array byte address of the request |
| wrsrCommit | input | 1 | A write-status command has completed this cycle |
| wrsrData | input | 8 | Data byte of the write-status command |
| allow | output | 1 | Request is permitted |
| statusByte | output | 8 | Status byte for read-back |

## Verification
A wrong protect-enable or level bit shows on the status byte in the first idle cycle after the faulty update. It also shows on `allow` as soon as a request is aimed at a boundary quarter of the array or at the status register. A commit that is wrongly accepted or dropped shows one clock later as a changed or unchanged bit 7 or bits 3:2. A defect in the pin gate shows only with the pin low and protect-enable set. The stimulus therefore visits that corner both for status requests and for commits.

// File: rtl/wp_status_pkg.sv
package wp_status_pkg;
  localparam int STATUS_W = 8;
  localparam int LEVEL_W  = 2;
  localparam int BIT_PEN  = 7;
  localparam int BIT_LVL_HI = 3;
  localparam int BIT_LVL_LO = 2;

  typedef enum logic [LEVEL_W-1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } protLevel_t;

  typedef struct packed {
    logic loadStatus;
  } ctlStrobes_t;
endpackage

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wp_status_pkg::*;
(
  input  logic        wpPinN,
  input  logic        welSet,
  input  logic        busy,
  input  logic        reqValid,
  input  logic        reqIsStatus,
  input  logic        wrsrCommit,
  input  logic        penQ,
  input  logic        addrLocked,
  output logic        allow,
  output ctlStrobes_t strobes
);
  logic hwLock;
  logic canWrite;
  logic statusOpen;

  always_comb begin
    hwLock     = ~wpPinN & penQ;
    canWrite   = welSet & ~busy;
    statusOpen = canWrite & ~hwLock;
    if (!reqValid) begin
      allow = 1'b0;
    end else if (reqIsStatus) begin
      allow = statusOpen;
    end else begin
      allow = canWrite & ~addrLocked;
    end
    strobes.loadStatus = wrsrCommit & statusOpen;
  end
endmodule

// File: rtl/wp_status_dp.sv
module wp_status_dp
  import wp_status_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [STATUS_W-1:0] wrsrData,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                welSet,
  input  logic                busy,
  output logic                penQ,
  output logic                addrLocked,
  output logic [STATUS_W-1:0] statusByte
);
  localparam int HI_LSB = ADDR_W - 2;

  protLevel_t  levelQ;
  logic [1:0]  addrHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      penQ   <= 1'b0;
      levelQ <= LVL_NONE;
    end else if (strobes.loadStatus) begin
      penQ   <= wrsrData[BIT_PEN];
      levelQ <= protLevel_t'(wrsrData[BIT_LVL_HI:BIT_LVL_LO]);
    end
  end

  assign addrHi = reqAddr[ADDR_W-1:HI_LSB];

  always_comb begin
    unique case (levelQ)
      LVL_NONE:    addrLocked = 1'b0;
      LVL_QUARTER: addrLocked = (addrHi == 2'b11);
      LVL_HALF:    addrLocked = addrHi[1];
      default:     addrLocked = 1'b1;
    endcase
  end

  always_comb begin
    if (busy) begin
      statusByte = '1;
    end else begin
      statusByte = '0;
      statusByte[BIT_PEN] = penQ;
      statusByte[BIT_LVL_HI:BIT_LVL_LO] = levelQ;
      statusByte[1] = welSet;
    end
  end
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wp_status_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpPinN,
  input  logic              welSet,
  input  logic              busy,
  input  logic              reqValid,
  input  logic              reqIsStatus,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              wrsrCommit,
  input  logic [7:0]        wrsrData,
  output logic              allow,
  output logic [7:0]        statusByte
);
  ctlStrobes_t strobes;
  logic        penQ;
  logic        addrLocked;

  wp_status_ctrl ctrl_i (
    .wpPinN(wpPinN), .welSet(welSet), .busy(busy), .reqValid(reqValid),
    .reqIsStatus(reqIsStatus), .wrsrCommit(wrsrCommit), .penQ(penQ),
    .addrLocked(addrLocked), .allow(allow), .strobes(strobes)
  );

  wp_status_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrsrData(wrsrData),
    .reqAddr(reqAddr), .welSet(welSet), .busy(busy), .penQ(penQ),
    .addrLocked(addrLocked), .statusByte(statusByte)
  );
endmodule

// File: rtl/wp_status_guard_chk.sv
module wp_status_guard_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              wpPinN,
  input logic              welSet,
  input logic              busy,
  input logic              reqValid,
  input logic              reqIsStatus,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              allow,
  input logic [7:0]        statusByte
);
  AST_BUSY_ALL_ONES: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (statusByte == 8'hFF && !allow)); // R3
  AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (!rstN)
    !welSet |-> !allow); // R4
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !allow); // R10
  AST_IDLE_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (statusByte[6:4] == 3'b000 && !statusByte[0] && statusByte[1] == welSet)); // R2
  AST_FULL_LEVEL_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && statusByte[3:2] == 2'b11 && !reqIsStatus) |-> !allow); // R5
  AST_QUARTER_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && statusByte[3:2] == 2'b01 && !reqIsStatus && reqAddr[ADDR_W-1:ADDR_W-2] == 2'b11) |-> !allow); // R5
  AST_HW_STATUS_DENY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && statusByte[7] && !wpPinN && reqIsStatus) |-> !allow); // R6
  AST_PEN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && !wpPinN && $past(!wpPinN) && $past(statusByte[7])) |-> statusByte[7]); // R9
endmodule

bind wp_status_guard wp_status_guard_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .wpPinN(wpPinN), .welSet(welSet), .busy(busy),
  .reqValid(reqValid), .reqIsStatus(reqIsStatus), .reqAddr(reqAddr),
  .allow(allow), .statusByte(statusByte)
);

// File: tb/wp_status_guard_tb_top.sv
module wp_status_guard_tb_top;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wpPinN = 1'b1, welSet = 1'b0, busy = 1'b0;
  logic reqValid = 1'b0, reqIsStatus = 1'b0, wrsrCommit = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] wrsrData = '0;
  logic allow;
  logic [7:0] statusByte;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic       mPen = 1'b0;
  logic [1:0] mLvl = 2'b00;

  logic [8:0] expQ[$];
  string      tagQ[$];
  event       sampleEv;

  always #10 clk = ~clk;

  wp_status_guard #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .wpPinN(wpPinN), .welSet(welSet), .busy(busy),
    .reqValid(reqValid), .reqIsStatus(reqIsStatus), .reqAddr(reqAddr),
    .wrsrCommit(wrsrCommit), .wrsrData(wrsrData),
    .allow(allow), .statusByte(statusByte)
  );

  // R5 quarter decoding on the top two address bits
  function automatic logic locked(input logic [1:0] lvl, input logic [1:0] hi);
    case (lvl)
      2'b00:   return 1'b0;
      2'b01:   return hi == 2'b11;
      2'b10:   return hi >= 2'b10;
      default: return 1'b1;
    endcase
  endfunction

  task automatic step(input logic wp, input logic wel, input logic bsy,
                      input logic v, input logic st, input logic [1:0] hi,
                      input logic cm, input logic [7:0] d, input string tag);
    logic expAllow;
    logic [7:0] expStat;
    logic hw;
    @(negedge clk);
    wpPinN = wp; welSet = wel; busy = bsy; reqValid = v; reqIsStatus = st;
    reqAddr = {hi, {(AW-2){1'b0}}} | AW'(5); wrsrCommit = cm; wrsrData = d;
    hw = ~wp & mPen;
    expAllow = v & wel & ~bsy & (st ? ~hw : ~locked(mLvl, hi));
    expStat  = bsy ? 8'hFF : {mPen, 3'b000, mLvl, wel, 1'b0};
    expQ.push_back({expAllow, expStat});
    tagQ.push_back(tag);
    -> sampleEv;
    @(posedge clk);
    if (cm && wel && !bsy && !hw) begin
      mPen = d[7];
      mLvl = d[3:2];
    end
  endtask

  initial begin : monitor
    forever begin
      @(sampleEv);
      #2;
      begin
        logic [8:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({allow, statusByte} !== e) begin
          failures++;
          $display("FAIL %s: allow=%0b status=%02h expected allow=%0b status=%02h",
                   t, allow, statusByte, e[8], e[7:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    //   wp  wel bsy v   st  hi    cm  data
    step(1, 0, 0, 0, 0, 2'd0, 0, 8'h00, "R1 reset status");
    step(1, 1, 0, 0, 0, 2'd3, 0, 8'h00, "R10 no request");
    step(1, 1, 0, 0, 1, 2'd0, 0, 8'h00, "R2 latch bit shown");
    step(1, 0, 0, 1, 0, 2'd0, 0, 8'h00, "R4 latch clear array");
    step(1, 0, 0, 1, 1, 2'd0, 0, 8'h00, "R4 latch clear status");
    step(1, 1, 1, 1, 0, 2'd0, 0, 8'h00, "R3 busy all ones");
    step(1, 1, 0, 1, 0, 2'd3, 0, 8'h00, "R5 level none top");
    // R8 commit 0xF7: only bit7 and bits3:2 (=01) kept
    step(1, 1, 0, 0, 0, 2'd0, 1, 8'hF7, "R8 commit cycle");
    step(1, 1, 0, 0, 0, 2'd0, 0, 8'h00, "R8 status 86");
    for (int h = 0; h < 4; h++) step(1, 1, 0, 1, 0, 2'(h), 0, 8'h00, "R5 quarter level");
    step(0, 1, 0, 1, 1, 2'd0, 0, 8'h00, "R6 pin low status denied");
    step(0, 1, 0, 1, 0, 2'd0, 0, 8'h00, "R7 unprotected array under pin");
    step(0, 1, 0, 1, 0, 2'd2, 0, 8'h00, "R7 quarter boundary under pin");
    step(0, 1, 0, 0, 0, 2'd0, 1, 8'h00, "R9 commit under pin");
    step(0, 1, 0, 0, 0, 2'd0, 0, 8'h00, "R9 enable stays set");
    step(1, 1, 0, 1, 1, 2'd0, 0, 8'h00, "R6 pin high status allowed");
    step(1, 1, 0, 0, 0, 2'd0, 1, 8'h08, "R8 commit half level");
    step(1, 1, 0, 0, 0, 2'd0, 0, 8'h00, "R8 status 0A");
    for (int h = 0; h < 4; h++) step(1, 1, 0, 1, 0, 2'(h), 0, 8'h00, "R5 half level");
    step(0, 1, 0, 1, 1, 2'd0, 0, 8'h00, "R6 pin low enable clear");
    step(1, 0, 0, 0, 0, 2'd0, 1, 8'h8C, "R9 commit latch clear");
    step(1, 1, 0, 0, 0, 2'd0, 0, 8'h00, "R9 unchanged after latch clear");
    step(1, 1, 1, 0, 0, 2'd0, 1, 8'h8C, "R9 commit while busy");
    step(1, 1, 0, 0, 0, 2'd0, 0, 8'h00, "R9 unchanged after busy");
    step(0, 1, 0, 0, 0, 2'd0, 1, 8'h8C, "R8 commit pin low enable clear");
    for (int h = 0; h < 4; h++) step(0, 1, 0, 1, 0, 2'(h), 0, 8'h00, "R5 all level");
    step(1, 1, 0, 1, 1, 2'd0, 0, 8'h00, "R6 pin high after lock");
    step(1, 1, 0, 0, 0, 2'd0, 1, 8'h00, "R8 clear with pin high");
    step(0, 1, 0, 1, 0, 2'd3, 0, 8'h00, "R8 cleared level top");
    step(0, 1, 1, 1, 1, 2'd0, 0, 8'h00, "R3 busy status request");
    @(negedge clk);
    #5;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule